// File: doc/BRIEF.md
# Serial Converter Host Read Controller

This block is the host-side master for a 16-bit serial converter that shares its data-out pin with a ready flag. It drives a serial clock, a chip select and a data line toward the converter. On one request it runs one of three sequences. The first is a one-shot conversion. The second is a fixed number of data-register reads while the converter converts on its own. The third is a streaming session in which results are clocked out with no command byte until the host asks to stop.

End of conversion is seen only by watching the shared data/ready line while chip select is low. That line is passed through a two-stage synchronizer into the system clock domain. Every result is presented for one cycle on a valid/data port, both as the raw offset-binary code and as a two's-complement value. The serial clock half-period, the ready-return timeout and the repeat-count width are parameters.

Top module: `adc_host_reader`

## Requirements
- R1: During and after reset, `cs_n` and `sclk` are high, `din` is low, `req_ready` is high, and `done`, `res_valid` and `overrun` are low.
- R2: Operation code 0 (codes 3 and 0 behave the same) sends byte 0x10, then the mode byte (default 0x82), then waits for the ready line to go low. It then sends 0x38 and applies 16 clocks. It delivers exactly one result and pulses `done`.
- R3: Operation code 1 reads the data register `req_count` times. Each read is the byte 0x38 followed by 16 clocks and is issued only after ready is seen low. Between reads the controller waits for ready to go high, so every delivered result is a new conversion.
- R4: Operation code 2 sends 0x3C once. After that, each low ready is followed by 16 clocks with no command byte, and each of those reads delivers a result.
- R5: During streaming reads `din` stays low. A one-cycle `stop_req` is recorded, and the next read, started while ready is low, carries 0x38 (pattern 001110xx) on `din` during its first 8 clocks. The stream ends after that read's result is delivered. `din` never shows 32 consecutive ones at rising `sclk` edges.
- R6: Bytes are sent MSB first, with `din` changing while `sclk` is low. Result bits are taken MSB first at rising `sclk`, and `res_raw` equals the 16-bit word the converter shifted out.
- R7: `res_signed` equals `res_raw` minus 32768, that is, `res_raw` with bit 15 inverted. 0x0000 maps to -32768, 0x8000 to 0 and 0xFFFF to 32767.
- R8: If ready has not returned high within `TIMEOUT` cycles after a read that is not the last one, `overrun` rises and the sequence ends with `done` in the same cycle. `overrun` holds until the next request is accepted.
- R9: A request is accepted only while `req_ready` is high, and requests made while busy are ignored. `done` is a single-cycle pulse.
- R10: `sclk` idles high and every low or high phase lasts `HALF_DIV` system clocks. `cs_n` is low for the whole sequence and high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_op | input | 2 | 0 one-shot, 1 repeated read, 2 streaming, 3 as 0 |
| req_count | input | COUNT_W | Number of reads for operation 1 |
| stop_req | input | 1 | Ends a streaming session at the next ready |
| req_ready | output | 1 | High while idle |
| done | output | 1 | One-cycle pulse at sequence end |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_raw | output | WORD | Offset-binary result |
| res_signed | output | WORD | Two's-complement result |
| overrun | output | 1 | Ready failed to return high after a read |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Active-low chip select |
| din | output | 1 | Serial data to the converter |
| dout_rdy | input | 1 | Serial data and ready flag from the converter |

## Verification
The bench goes after the ready handshake in four places. It issues a one-shot request while the converter still holds a stale result; a controller that did not wait for the mode write would read too early and deliver the old code. It starves the ready release so that the line stays low after a read; a controller that trusted stale synchronizer contents would read the same result twice instead of raising the overrun flag. It stops a stream between two conversions; a controller that sent the exit byte outside a read would be seen by the responder as a command it never accepts, and the stream would continue. Codes at negative full scale, zero and positive full scale expose a wrong bit-15 inversion, and a request fired during a busy sequence exposes an interlock that lets a second command stream start.

// File: rtl/adc_host_pkg.sv
// Package: shared operation codes, controller states and command bytes.
// Assumes an 8-bit command path and a converter that accepts these codes.
package adc_host_pkg;
    typedef enum logic [1:0] {
        OP_SINGLE = 2'd0,
        OP_REPEAT = 2'd1,
        OP_STREAM = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_COMM, S_MODE, S_RDCMD, S_READ, S_WLO, S_WHI, S_ENTER
    } st_e;

    localparam logic [7:0] CMD_SEL_MODE   = 8'h10;
    localparam logic [7:0] CMD_READ_DATA  = 8'h38;
    localparam logic [7:0] CMD_STREAM_ON  = 8'h3C;
    localparam logic [7:0] CMD_STREAM_OFF = 8'h38;
endpackage

// File: rtl/rdy_sync.sv
// Module: multi-stage synchronizer for the shared data/ready line.
// Assumes the input may change at any time; resets to "not ready" (high).
module rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // shift the sampled line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
// Module: serial shift engine. One start moves either a command byte or a
// full data word. SCLK idles high, the output bit changes in the low phase,
// and the input is captured as SCLK rises. Assumes start only while idle.
module ser_shift #(
    parameter int HALF_DIV = 2,
    parameter int WORD     = 16,
    parameter int CMD      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            long_xfer,
    input  logic [CMD-1:0]  tx,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [WORD-1:0] rx
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(WORD + 1);

    logic [DW-1:0]   div_q;
    logic            hi_q;
    logic [BW-1:0]   left_q;
    logic [WORD-1:0] tx_q;

    // phase timing, bit counting, transmit shift and receive capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            hi_q   <= 1'b0;
            div_q  <= '0;
            left_q <= '0;
            tx_q   <= '0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                hi_q   <= 1'b0;
                div_q  <= '0;
                left_q <= long_xfer ? BW'(WORD - 1) : BW'(CMD - 1);
                tx_q   <= {tx, {(WORD-CMD){1'b0}}};
            end else if (busy) begin
                if (div_q == DW'(HALF_DIV - 1)) begin
                    div_q <= '0;
                    if (!hi_q) begin
                        hi_q <= 1'b1;
                        rx   <= {rx[WORD-2:0], miso};
                    end else begin
                        hi_q <= 1'b0;
                        if (left_q == '0) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            left_q <= left_q - 1'b1;
                            tx_q   <= {tx_q[WORD-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign sclk = !(busy && !hi_q);
    assign mosi = busy & tx_q[WORD-1];
endmodule

// File: rtl/adc_host_reader.sv
// Module: host read controller for a 16-bit serial converter. It sequences
// one-shot, repeated and streaming reads, detects ready on the shared data
// line through a synchronizer, and flags a ready line that fails to release.
// Assumes the converter drives its data line only while cs_n is low.
module adc_host_reader
    import adc_host_pkg::*;
#(
    parameter int         HALF_DIV  = 2,
    parameter int         WORD      = 16,
    parameter int         COUNT_W   = 8,
    parameter int         TIMEOUT   = 64,
    parameter int         SYNC_LAT  = 2,
    parameter logic [7:0] MODE_BYTE = 8'h82
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               stop_req,
    output logic               req_ready,
    output logic               done,
    output logic               res_valid,
    output logic [WORD-1:0]    res_raw,
    output logic [WORD-1:0]    res_signed,
    output logic               overrun,
    output logic               sclk,
    output logic               cs_n,
    output logic               din,
    input  logic               dout_rdy
);
    localparam int TW = $clog2(TIMEOUT + 1);

    st_e                state;
    op_e                op_q;
    logic [COUNT_W-1:0] cnt_q;
    logic [TW-1:0]      wcnt_q;
    logic               stop_q, exit_q;
    logic               go_q, long_q;
    logic [7:0]         tx_q;
    logic               sh_busy, sh_done;
    logic [WORD-1:0]    sh_rx;
    logic               rdy_s, settled;

    rdy_sync #(.STAGES(SYNC_LAT)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n | dout_rdy), .q(rdy_s)
    );

    ser_shift #(.HALF_DIV(HALF_DIV), .WORD(WORD), .CMD(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(go_q), .long_xfer(long_q),
        .tx(tx_q), .miso(dout_rdy), .sclk(sclk), .mosi(din),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx)
    );

    assign settled    = (wcnt_q >= TW'(SYNC_LAT));
    assign req_ready  = (state == S_IDLE);
    assign res_signed = {~res_raw[WORD-1], res_raw[WORD-2:0]};

    // sequence controller: request intake, waits, launches, result delivery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_q      <= OP_SINGLE;
            cnt_q     <= '0;
            wcnt_q    <= '0;
            stop_q    <= 1'b0;
            exit_q    <= 1'b0;
            go_q      <= 1'b0;
            long_q    <= 1'b0;
            tx_q      <= '0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            res_valid <= 1'b0;
            res_raw   <= '0;
            overrun   <= 1'b0;
        end else begin
            go_q      <= 1'b0;
            done      <= 1'b0;
            res_valid <= 1'b0;
            if (state != S_IDLE && op_q == OP_STREAM && stop_req) stop_q <= 1'b1;
            if ((state == S_WLO || state == S_WHI) && wcnt_q != TW'(TIMEOUT))
                wcnt_q <= wcnt_q + 1'b1;
            case (state)
                S_IDLE: if (req_valid) begin
                    cnt_q   <= req_count;
                    overrun <= 1'b0;
                    stop_q  <= 1'b0;
                    exit_q  <= 1'b0;
                    cs_n    <= 1'b0;
                    wcnt_q  <= '0;
                    case (req_op)
                        2'd1: begin op_q <= OP_REPEAT; state <= S_WLO; end
                        2'd2: begin
                            op_q <= OP_STREAM; state <= S_ENTER;
                            go_q <= 1'b1; long_q <= 1'b0; tx_q <= CMD_STREAM_ON;
                        end
                        default: begin
                            op_q <= OP_SINGLE; state <= S_COMM;
                            go_q <= 1'b1; long_q <= 1'b0; tx_q <= CMD_SEL_MODE;
                        end
                    endcase
                end
                S_COMM: if (sh_done) begin
                    state <= S_MODE; go_q <= 1'b1; long_q <= 1'b0; tx_q <= MODE_BYTE;
                end
                S_MODE, S_ENTER: if (sh_done) begin
                    state <= S_WLO; wcnt_q <= '0;
                end
                S_WLO: if (settled && !rdy_s) begin
                    go_q <= 1'b1;
                    if (op_q == OP_STREAM) begin
                        state  <= S_READ; long_q <= 1'b1; exit_q <= stop_q;
                        tx_q   <= stop_q ? CMD_STREAM_OFF : 8'h00;
                    end else begin
                        state <= S_RDCMD; long_q <= 1'b0; tx_q <= CMD_READ_DATA;
                    end
                end
                S_RDCMD: if (sh_done) begin
                    state <= S_READ; go_q <= 1'b1; long_q <= 1'b1; tx_q <= 8'h00;
                end
                S_READ: if (sh_done) begin
                    res_valid <= 1'b1;
                    res_raw   <= sh_rx;
                    if (op_q == OP_SINGLE || exit_q ||
                        (op_q == OP_REPEAT && cnt_q <= COUNT_W'(1))) begin
                        state <= S_IDLE; cs_n <= 1'b1; done <= 1'b1;
                    end else begin
                        cnt_q  <= cnt_q - 1'b1;
                        state  <= S_WHI;
                        wcnt_q <= '0;
                    end
                end
                S_WHI: if (settled && rdy_s) begin
                    state <= S_WLO; wcnt_q <= '0;
                end else if (wcnt_q == TW'(TIMEOUT)) begin
                    overrun <= 1'b1; state <= S_IDLE; cs_n <= 1'b1; done <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: done never lasts more than one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a rising overrun always closes the sequence in the same cycle
    a_r8_overrun_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (done && cs_n));
    // R10: the serial clock rests high whenever the converter is deselected
    a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R5: plain streaming reads keep the data line low
    a_r5_din_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && op_q == OP_STREAM && !exit_q) |-> !din);
    // R6: a result appears only right after a data read finished
    a_r6_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(state) == S_READ && !sh_busy));
    // R10: select stays asserted while a sequence runs
    a_r10_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && $past(state) != S_IDLE) |-> !cs_n);
endmodule

// File: tb/adc_host_reader_tb.sv
// Bench: behavioural converter responder, result queue reference and per-clock checks.
module adc_host_reader_tb;
    localparam int HALF = 2, TOUT = 64, CONV = 400, SCONV = 250;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       req_valid = 1'b0, stop_req = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_count = 8'd0;
    wire        req_ready, done, res_valid, overrun, sclk, cs_n, din;
    wire [15:0] res_raw, res_signed;
    logic       dout_r = 1'b1;
    wire        dout_rdy = cs_n ? 1'b1 : dout_r;

    adc_host_reader #(.HALF_DIV(HALF), .TIMEOUT(TOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_count(req_count), .stop_req(stop_req), .req_ready(req_ready),
        .done(done), .res_valid(res_valid), .res_raw(res_raw),
        .res_signed(res_signed), .overrun(overrun), .sclk(sclk),
        .cs_n(cs_n), .din(din), .dout_rdy(dout_rdy)
    );

    int checks = 0, fails = 0;
    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] samp(int i);
        case (i)
            0: return 16'hA5C3;  1: return 16'h0000;  2: return 16'h8000;
            3: return 16'hFFFF;  4: return 16'h7FFF;  5: return 16'h0001;
            default: return 16'(i * 977 + 3);
        endcase
    endfunction

    // converter responder state
    bit cont_conv = 1, stream = 0, stuck = 0, pending = 0, rd_act = 0;
    bit want_mode = 0, exit_seen = 0, din_dirty = 0;
    int conv_cnt = CONV, sidx = 0, bitn = 0, one_run = 0, max_run = 0;
    logic [15:0] latest = 16'h0, word = 16'h0, rxw = 16'h0;
    logic [7:0]  cmdw = 8'h0;
    logic        sclk_p = 1'b1;
    logic [15:0] exp_q[$];
    logic [7:0]  cmd_log[$];

    // converter model: conversions, command decode, data shift-out
    always @(negedge clk) begin
        bit fall, rise;
        fall = (sclk_p === 1'b1) && (sclk === 1'b0);
        rise = (sclk_p === 1'b0) && (sclk === 1'b1);
        sclk_p = sclk;
        if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) begin
                if (!rd_act) begin latest = samp(sidx); sidx++; pending = 1; end
                if (cont_conv) conv_cnt = CONV;
            end
        end
        if (cs_n !== 1'b0) begin
            bitn = 0; rd_act = 0; cmdw = 8'h0;
        end else begin
            if (fall && !rd_act && stream && pending) begin
                rd_act = 1; word = latest; bitn = 0; rxw = 16'h0;
            end
            if (fall && rd_act) dout_r = word[15-bitn];
            if (rise) begin
                if (din) one_run++; else one_run = 0;
                if (one_run > max_run) max_run = one_run;
                if (rd_act) begin
                    rxw = {rxw[14:0], din}; bitn++;
                    if (bitn == 16) begin
                        rd_act = 0; bitn = 0; exp_q.push_back(word);
                        if (!stuck) pending = 0;
                        if (stream) begin
                            if (rxw[15:10] == 6'b001110) begin stream = 0; exit_seen = 1; end
                            else if (rxw != 16'h0) din_dirty = 1;
                        end
                    end
                end else begin
                    cmdw = {cmdw[6:0], din}; bitn++;
                    if (bitn == 8) begin
                        bitn = 0; cmd_log.push_back(cmdw);
                        if (want_mode) begin
                            want_mode = 0;
                            if (cmdw[7:6] == 2'b10) begin cont_conv = 0; pending = 0; conv_cnt = SCONV; end
                        end else if (cmdw == 8'h10) want_mode = 1;
                        else if (cmdw == 8'h38) begin rd_act = 1; word = latest; rxw = 16'h0; end
                        else if (cmdw == 8'h3C) stream = 1;
                    end
                end
            end
        end
        if (!rd_act) dout_r = !pending;
    end

    // reference comparison every clock
    int res_cnt = 0, done_cnt = 0, inv_bad = 0, lowlen = 0, lmin = 1000, lmax = 0;
    bit done_flag = 0;
    always @(negedge clk) if (rst_n) begin
        if (done) begin done_cnt++; done_flag = 1; end
        if (res_valid) begin
            res_cnt++;
            if (exp_q.size() == 0) chk(0, "R6", "unexpected result", res_raw, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(res_raw == e, "R6", "raw result", res_raw, e);
                chk(int'($signed(res_signed)) == int'(e) - 32768, "R7", "signed result",
                    res_signed, e ^ 16'h8000);
            end
        end
        if (cs_n && !sclk) inv_bad++;
        if (req_ready && !cs_n) inv_bad++;
        if (!sclk) lowlen++;
        else if (lowlen > 0) begin
            if (lowlen < lmin) lmin = lowlen;
            if (lowlen > lmax) lmax = lowlen;
            lowlen = 0;
        end
    end

    task automatic issue(logic [1:0] op, logic [7:0] n);
        @(negedge clk); req_op = op; req_count = n; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_flag) @(negedge clk);
        done_flag = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int r0;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !din && req_ready && !done && !res_valid && !overrun, "R1",
            "reset outputs", {cs_n, sclk, din, req_ready, done, res_valid, overrun}, 7'b1101000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 one-shot, with an ignored request during the busy period (R9)
        cmd_log.delete(); r0 = res_cnt;
        issue(2'd0, 8'd0);
        req_valid = 1'b1; req_op = 2'd1; req_count = 8'd5;
        @(negedge clk); req_valid = 1'b0;
        wait_done();
        chk(cmd_log.size() == 3, "R9", "command count in one-shot", cmd_log.size(), 3);
        chk(cmd_log.size() == 3 && cmd_log[0] == 8'h10 && cmd_log[1] == 8'h82 && cmd_log[2] == 8'h38,
            "R2", "one-shot command order", cmd_log.size() > 2 ? cmd_log[1] : 0, 8'h82);
        chk(res_cnt - r0 == 1, "R2", "one-shot result count", res_cnt - r0, 1);
        repeat (50) @(negedge clk);
        chk(cs_n && req_ready, "R9", "idle after one-shot", cs_n, 1);

        // R3 repeated reads in continuous conversion
        cont_conv = 1; conv_cnt = CONV; cmd_log.delete(); r0 = res_cnt;
        issue(2'd1, 8'd3);
        wait_done();
        chk(res_cnt - r0 == 3, "R3", "repeat result count", res_cnt - r0, 3);
        chk(cmd_log.size() == 3 && cmd_log[0] == 8'h38 && cmd_log[2] == 8'h38,
            "R3", "repeat commands", cmd_log.size(), 3);

        // R4/R5 streaming session with stop
        cmd_log.delete(); r0 = res_cnt;
        issue(2'd2, 8'd0);
        while (res_cnt - r0 < 2) @(negedge clk);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        wait_done();
        chk(cmd_log.size() == 1 && cmd_log[0] == 8'h3C, "R4", "stream entry only",
            cmd_log.size(), 1);
        chk(res_cnt - r0 == 3, "R4", "stream result count", res_cnt - r0, 3);
        chk(exit_seen && !stream, "R5", "exit accepted while ready low", exit_seen, 1);
        chk(!din_dirty, "R5", "din low in stream reads", din_dirty, 0);

        // R8 overrun when ready never releases
        stuck = 1; r0 = res_cnt;
        issue(2'd1, 8'd3);
        wait_done();
        chk(overrun, "R8", "overrun raised", overrun, 1);
        chk(res_cnt - r0 == 1, "R8", "reads before overrun", res_cnt - r0, 1);
        repeat (10) @(negedge clk);
        chk(overrun, "R8", "overrun held", overrun, 1);
        stuck = 0;
        issue(2'd1, 8'd1);
        chk(!overrun, "R8", "overrun cleared on accept", overrun, 0);
        wait_done();
        chk(!overrun, "R8", "no overrun on clean read", overrun, 0);

        chk(max_run < 32, "R5", "longest din ones run", max_run, 31);
        chk(lmin == HALF && lmax == HALF, "R10", "sclk low phase", lmax, HALF);
        chk(inv_bad == 0, "R10", "select and clock idle rules", inv_bad, 0);
        chk(exp_q.size() == 0, "R6", "all reads delivered", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule